// File: doc/BRIEF.md
# Proximity-Card Command Frame Receiver

This block turns a stream of sliced one-bit field samples into the bytes of a reader-to-card command frame for a Type B proximity link. Each bit period spans a fixed number of samples, and each sample is marked by a valid strobe. The receiver first looks for the long low phase that opens a frame. It then times the high gap that follows and assembles ten-bit characters. Each good character is written out through a byte write port into a buffer that sits outside the block. When the all-zero closing character arrives, the block raises a one-cycle completion pulse carrying the byte count.

Any framing violation sends the receiver straight back to hunting for a new frame. This covers an opening low phase that is too short or too long, an over-long gap between characters, a bad start or stop bit, and a frame that fills the buffer. There is no recovery delay after such an error. CRC checking and command decoding belong to the logic that reads the buffer.

Top module: `pcd_frame_rx`

## Requirements
- R1: After `rst_ni` is low, or after a cycle with `clr_i` high, all outputs are zero and any partly received frame is discarded: it produces no completion pulse, even when a closing character follows.
- R2: A character is a start bit 0, then eight data bits least-significant bit first, then a stop bit 1. The first low sample seen while waiting for a start bit is sample 0 of the start bit. Each bit is taken from sample SPB/2 of its own period, where SPB (samples per bit) defaults to 2.
- R3: Each good character produces one cycle of `wr_en_o`, in the cycle after the clock edge that consumed the centre sample of its stop bit. The write carries the data byte and the address 0, 1, 2 and so on, in arrival order within the frame.
- R4: A frame opens with a run of low bit periods followed by a high bit period. A run of 10 to 12 periods is accepted. A run of 9 or fewer, or of 13 or more, returns the block to unsynchronised, and that frame produces no write and no completion.
- R5: While waiting for a start bit, up to 25 consecutive high samples are allowed. These are counted from the centre sample of the last stop bit, or of the first high period after the opening low run. A 26th high sample returns the block to unsynchronised, and that frame never completes.
- R6: A character whose ten bits are all zero closes the frame. If at least one byte was written, `done_o` is high for one cycle with `done_len_o` equal to the number of bytes written. If no byte was written, nothing is reported.
- R7: A character with a start bit of 1 or a stop bit of 0, other than the all-zero closing character, is not written and returns the block to unsynchronised. That frame produces no completion.
- R8: When the byte count reaches MAX_FRAME (default 16) after a write, the frame is abandoned. All MAX_FRAME bytes are written, but no completion follows. A frame of MAX_FRAME-1 bytes completes normally.
- R9: A cycle with `sample_vld_i` low is ignored: it advances no timer, no counter and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear back to the reset state |
| sample_vld_i | input | 1 | Qualifies `sample_i` for this cycle |
| sample_i | input | 1 | Sliced field level |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | $clog2(MAX_FRAME) | Byte position within the frame |
| wr_data_o | output | 8 | Received data byte |
| done_o | output | 1 | Frame complete, one cycle |
| done_len_o | output | $clog2(MAX_FRAME+1) | Byte count of the completed frame |

## Verification
A wrong position counter or shift count moves the sampling point onto a neighbouring bit. The first data byte then comes out rotated or framed as bad, and this is seen at the first write, about eleven bit periods after the opening low run. A wrong state or a wrong limit on the opening-run or gap counter shows up differently: a frame at the edge of its window either completes when it should not or stays silent, which is visible only when the closing character arrives. The checks therefore sweep frame length and opening-run length, and they place gaps and run lengths on both sides of each limit.

// File: rtl/pcd_rx_pkg.sv
package pcd_rx_pkg;
  typedef enum logic [1:0] {
    ST_UNSYNC,
    ST_SOF_LOW,
    ST_WAIT_START,
    ST_DATA
  } rx_state_e;

  localparam int unsigned CHAR_W = 10;
endpackage

// File: rtl/pcd_rx_bitclk.sv
module pcd_rx_bitclk #(
  parameter int unsigned SPB = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic restart_i,
  output logic strobe_o
);
  localparam int unsigned PW   = (SPB > 2) ? $clog2(SPB) : 1;
  localparam int unsigned HALF = SPB / 2;

  logic [PW-1:0] pos_q, pos_nx;

  always_comb pos_nx = (pos_q == PW'(SPB - 1)) ? '0 : pos_q + 1'b1;

  assign strobe_o = vld_i && !restart_i && !clr_i && (pos_nx == PW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (clr_i)   pos_q <= '0;
    else if (vld_i)   pos_q <= restart_i ? '0 : pos_nx;
  end

  // R2: at most one centre sample per bit period
  p_strobe_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/pcd_rx_shift.sv
module pcd_rx_shift #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [CW-1:0] word_o,
  output logic          last_o
);
  localparam int unsigned NW = $clog2(CW);

  logic [CW-1:0] sh_q;
  logic [NW-1:0] cnt_q;

  assign word_o = {bit_i, sh_q[CW-1:1]};
  assign last_o = shift_i && (cnt_q == NW'(CW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i || load_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= word_o;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: bit count stays inside one character
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < NW'(CW));
endmodule

// File: rtl/pcd_frame_rx.sv
module pcd_frame_rx
  import pcd_rx_pkg::*;
#(
  parameter int unsigned SPB       = 2,
  parameter int unsigned SOF_MIN   = 10,
  parameter int unsigned SOF_MAX   = 12,
  parameter int unsigned IDLE_MAX  = 25,
  parameter int unsigned MAX_FRAME = 16,
  localparam int unsigned AW = $clog2(MAX_FRAME),
  localparam int unsigned LW = $clog2(MAX_FRAME + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          sample_vld_i,
  input  logic          sample_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          done_o,
  output logic [LW-1:0] done_len_o
);
  localparam int unsigned ZW = $clog2(SOF_MAX + 1);
  localparam int unsigned IW = $clog2(IDLE_MAX + 1);

  rx_state_e   state_q, state_d;
  logic [LW-1:0] bcnt_q, bcnt_d;
  logic [ZW-1:0] zcnt_q, zcnt_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          wr_d, done_d;

  logic              restart, strobe, last;
  logic [CHAR_W-1:0] word;
  logic              char_ok, char_eof;

  assign restart = sample_vld_i && !sample_i &&
                   (state_q == ST_UNSYNC || state_q == ST_WAIT_START);

  pcd_rx_bitclk #(.SPB(SPB)) u_bitclk (
    .clk_i, .rst_ni, .clr_i,
    .vld_i    (sample_vld_i),
    .restart_i(restart),
    .strobe_o (strobe)
  );

  pcd_rx_shift #(.CW(CHAR_W)) u_shift (
    .clk_i, .rst_ni, .clr_i,
    .load_i (restart),
    .shift_i(strobe && state_q == ST_DATA),
    .bit_i  (sample_i),
    .word_o (word),
    .last_o (last)
  );

  assign char_ok  = !word[0] && word[CHAR_W-1];
  assign char_eof = (word == '0);

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    zcnt_d  = zcnt_q;
    idle_d  = idle_q;
    wr_d    = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_UNSYNC: if (sample_vld_i && !sample_i) begin
        state_d = ST_SOF_LOW;
        zcnt_d  = '0;
        bcnt_d  = '0;
      end
      ST_SOF_LOW: if (strobe) begin
        if (sample_i) begin
          state_d = (zcnt_q >= ZW'(SOF_MIN)) ? ST_WAIT_START : ST_UNSYNC;
          idle_d  = '0;
        end else if (zcnt_q == ZW'(SOF_MAX)) begin
          state_d = ST_UNSYNC;
        end else begin
          zcnt_d = zcnt_q + 1'b1;
        end
      end
      ST_WAIT_START: if (sample_vld_i) begin
        if (!sample_i)                    state_d = ST_DATA;
        else if (idle_q == IW'(IDLE_MAX)) state_d = ST_UNSYNC;
        else                              idle_d  = idle_q + 1'b1;
      end
      ST_DATA: if (last) begin
        if (char_ok) begin
          wr_d   = 1'b1;
          bcnt_d = bcnt_q + 1'b1;
          idle_d = '0;
          state_d = (bcnt_q + LW'(1) == LW'(MAX_FRAME)) ? ST_UNSYNC : ST_WAIT_START;
        end else begin
          state_d = ST_UNSYNC;
          done_d  = char_eof && (bcnt_q != '0);
        end
      end
      default: state_d = ST_UNSYNC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_UNSYNC;
      bcnt_q     <= '0;
      zcnt_q     <= '0;
      idle_q     <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      done_o     <= 1'b0;
      done_len_o <= '0;
    end else if (clr_i) begin
      state_q    <= ST_UNSYNC;
      bcnt_q     <= '0;
      zcnt_q     <= '0;
      idle_q     <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      done_o     <= 1'b0;
      done_len_o <= '0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      zcnt_q  <= zcnt_d;
      idle_q  <= idle_d;
      wr_en_o <= wr_d;
      done_o  <= done_d;
      if (wr_d) begin
        wr_addr_o <= bcnt_q[AW-1:0];
        wr_data_o <= word[8:1];
      end
      if (done_d) done_len_o <= bcnt_q;
    end
  end

  p_done_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> done_len_o != '0);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_wr_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    wr_en_o |-> bcnt_q == LW'(wr_addr_o) + LW'(1));

  p_sof_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SOF_LOW |-> zcnt_q <= ZW'(SOF_MAX));

  p_idle_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT_START |-> idle_q <= IW'(IDLE_MAX));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_UNSYNC |-> bcnt_q < LW'(MAX_FRAME));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_vld_i && !clr_i) |=> $stable(state_q));
endmodule

// File: tb/pcd_frame_rx_tb_top.sv
`timescale 1ns/1ps
module pcd_frame_rx_tb_top;
  localparam int SPB = 2, SOF_MIN = 10, SOF_MAX = 12, IDLE_MAX = 25, MAXF = 16;
  localparam int AW = $clog2(MAXF), LW = $clog2(MAXF + 1);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, vld = 1'b0, smp = 1'b1;
  logic wr_en, done;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [LW-1:0] done_len;

  int total = 0, bad = 0;
  int obs_wr = 0, obs_done = 0, obs_len = 0;
  int obs_addr [32];
  int obs_data [32];
  bit gap_en = 1'b0;

  always #2.5 clk = ~clk;

  pcd_frame_rx #(.SPB(SPB), .SOF_MIN(SOF_MIN), .SOF_MAX(SOF_MAX),
                 .IDLE_MAX(IDLE_MAX), .MAX_FRAME(MAXF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sample_vld_i(vld), .sample_i(smp),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .done_len_o(done_len)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (obs_wr < 32) begin
        obs_addr[obs_wr] = int'(wr_addr);
        obs_data[obs_wr] = int'(wr_data);
      end
      obs_wr++;
    end
    if (done) begin
      obs_done++;
      obs_len = int'(done_len);
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 91 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic clear_obs();
    obs_wr = 0; obs_done = 0; obs_len = 0;
  endtask

  task automatic put(input logic b);
    if (gap_en) begin
      @(negedge clk); vld = 1'b0; smp = ~b;
    end
    @(negedge clk); vld = 1'b1; smp = b;
  endtask

  task automatic put_samples(input logic b, input int n);
    for (int k = 0; k < n; k++) put(b);
  endtask

  task automatic put_bits(input logic b, input int n);
    put_samples(b, n * SPB);
  endtask

  task automatic send_char(input logic [9:0] c);
    for (int k = 0; k < 10; k++) put_bits(c[k], 1);
  endtask

  task automatic frame_head(input int sof);
    put_bits(1'b1, 4); put_bits(1'b0, sof); put_bits(1'b1, 2);
  endtask

  task automatic frame_tail();
    put_bits(1'b0, 10);
    put_bits(1'b1, 30);
    @(negedge clk); vld = 1'b0; smp = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input int sof, input int gap, input int seed);
    frame_head(sof);
    for (int i = 0; i < n; i++) begin
      send_char({1'b1, pat(seed, i), 1'b0});
      put_samples(1'b1, gap);
    end
    frame_tail();
  endtask

  task automatic expect_frame(input string req, input int nw, input int nd,
                              input int len, input int seed);
    chk(obs_wr == nw, {req, " write count"}, obs_wr, nw);
    for (int i = 0; i < nw && i < obs_wr && i < 32; i++) begin
      chk(obs_addr[i] == i, {req, " write address"}, obs_addr[i], i);
      chk(obs_data[i] == int'(pat(seed, i)), {req, " write data"}, obs_data[i], int'(pat(seed, i)));
    end
    chk(obs_done == nd, {req, " done count"}, obs_done, nd);
    if (nd != 0) chk(obs_len == len, {req, " done length"}, obs_len, len);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0 && done == 1'b0, "R1 outputs in reset", int'(wr_en) + int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(wr_addr == '0 && done_len == '0, "R1 fields after reset", int'(wr_addr) + int'(done_len), 0);

    // R2 R3 R6: length sweep, opening run and gap varied
    for (int n = 1; n < MAXF; n++) begin
      clear_obs();
      send_frame(n, SOF_MIN + (n % 3), n % 4, n);
      expect_frame("R2 R3 R6 sweep", n, 1, n, n);
    end

    // R9 invalid cycles interleaved
    gap_en = 1'b1;
    clear_obs(); send_frame(5, 11, 1, 77);
    expect_frame("R9 gated samples", 5, 1, 5, 77);
    gap_en = 1'b0;

    // R4 opening run limits
    clear_obs(); send_frame(3, SOF_MIN - 1, 0, 5);
    expect_frame("R4 short opening run", 0, 0, 0, 5);
    clear_obs(); send_frame(3, SOF_MAX + 1, 0, 6);
    expect_frame("R4 long opening run", 0, 0, 0, 6);
    clear_obs(); send_frame(3, SOF_MAX, 0, 7);
    expect_frame("R4 max opening run", 3, 1, 3, 7);

    // R5 gap limit
    clear_obs(); send_frame(2, 10, IDLE_MAX, 8);
    expect_frame("R5 gap at limit", 2, 1, 2, 8);
    clear_obs(); send_frame(2, 10, IDLE_MAX + 1, 9);
    expect_frame("R5 gap over limit", 1, 0, 0, 9);

    // R6 empty frame
    clear_obs(); send_frame(0, 10, 0, 1);
    expect_frame("R6 empty frame", 0, 0, 0, 1);

    // R7 bad stop bit
    clear_obs();
    frame_head(10);
    send_char({1'b1, pat(11, 0), 1'b0});
    send_char({1'b0, pat(11, 1), 1'b0});
    frame_tail();
    expect_frame("R7 bad stop", 1, 0, 0, 11);

    // R7 bad start bit (half-bit glitch)
    clear_obs();
    frame_head(10);
    send_char({1'b1, pat(12, 0), 1'b0});
    put_samples(1'b0, 1);
    put_bits(1'b1, 12);
    send_char({1'b1, pat(12, 1), 1'b0});
    frame_tail();
    expect_frame("R7 bad start", 1, 0, 0, 12);

    // R8 overflow
    clear_obs(); send_frame(MAXF, 10, 0, 13);
    expect_frame("R8 full frame abandoned", MAXF, 0, 0, 13);
    clear_obs(); send_frame(MAXF - 1, 10, 0, 14);
    expect_frame("R8 one below limit", MAXF - 1, 1, MAXF - 1, 14);

    // R1 synchronous clear mid-frame
    clear_obs();
    frame_head(10);
    for (int i = 0; i < 3; i++) send_char({1'b1, pat(15, i), 1'b0});
    @(negedge clk); vld = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(wr_en == 1'b0 && done == 1'b0 && wr_addr == '0, "R1 outputs after clear",
        int'(wr_en) + int'(done) + int'(wr_addr), 0);
    frame_tail();
    expect_frame("R1 cleared frame", 3, 0, 0, 15);
    clear_obs(); send_frame(2, 10, 0, 16);
    expect_frame("R1 frame after clear", 2, 1, 2, 16);

    summary();
  end
endmodule